// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block is a host-side SPI master that runs read transactions against a page-organised serial flash. A request names one of several read kinds, a page number, an offset, a page-size mode and a byte count. The block lowers chip select and shifts out a command byte, three address bytes and however many zero filler bytes the kind needs. It then clocks in the requested data bytes and hands each one over a valid/ready stream. Finally it raises chip select and pulses `done`.

The serial clock comes from a divider: one half period lasts `HALF_DIV` system clocks. The link runs in SPI mode 0 with MSB first in both directions. A received byte that the consumer has not yet taken holds the serial clock low, so the block never loses data.

Top module: `flash_read_seq`

## Requirements
- R1: Chip select stays low without a break from the first command bit to the last data bit. Each request gives exactly one low window, carrying header bytes plus count data bytes. SCK is low whenever chip select is high.
- R2: The command byte depends on `req_kind`: 0 gives 03h, 1 gives D2h, 2 gives D4h, 3 gives D6h, 4 gives D1h and 5 gives D3h. The values 6 and 7 act as kind 0.
- R3: Filler bytes follow the address. There are none for kind 0, four for kind 1 and one for kinds 2 to 5. They are sent as 00h, and whatever arrives on MISO during the header is discarded.
- R4: For kinds 0 and 1 with `req_bin`=0, the 24 address bits are a zero bit, then `req_page`[12:0], then `req_offset`[9:0], sent MSB first.
- R5: For kinds 0 and 1 with `req_bin`=1, the address is two zero bits, then `req_page`[12:0], then `req_offset`[8:0]. Offset bit 9 is ignored.
- R6: For kinds 2 to 5 the page is ignored. With `req_bin`=0 the address is 14 zero bits followed by `req_offset`[9:0]. With `req_bin`=1 it is 15 zero bits followed by `req_offset`[8:0].
- R7: MOSI changes only on the cycle in which SCK falls or chip select falls. MISO is sampled at SCK rising, and data bytes are assembled MSB first.
- R8: Exactly `req_count` bytes come out on `rd_data` in arrival order. A byte offered with `rd_ready` low stays valid and unchanged, and SCK does not rise while a byte is waiting.
- R9: A count of zero sends the full header and then ends the transaction with no data byte.
- R10: `done` is a one-cycle pulse, issued in the cycle chip select returns high. `req_ready` is high only when the block is idle and no byte is pending. Chip select stays high for at least 4·`HALF_DIV` cycles between transactions.
- R11: The first SCK rise comes `HALF_DIV` cycles after chip select falls. Without back-pressure, consecutive rises are 2·`HALF_DIV` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 3 | Read kind (see R2) |
| req_page | input | 13 | Page number |
| req_offset | input | 10 | Byte or buffer offset |
| req_bin | input | 1 | 1 = 512-byte page mode, 0 = 528-byte |
| req_count | input | CNT_W | Number of data bytes to read |
| rd_valid | output | 1 | Data byte available |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_data | output | 8 | Received data byte |
| done | output | 1 | Transaction finished pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the block with `HALF_DIV`=2 and `CNT_W`=10. The short half period keeps each transaction to a few hundred cycles, so the bench can reach every read kind in both page-size modes, a zero-length read and a slow consumer that stalls the serial clock mid-stream. With a half period above one cycle, the bench can also measure the divider spacing and tell the SCK rise apart from the chip-select edge.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int PAGE_W   = 13;
    localparam int OFF_W    = 10;
    localparam int HDR_MAX  = 8;
    localparam int HDR_BITS = HDR_MAX * 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_XFER,
        S_TAIL,
        S_GAP
    } seq_state_e;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [23:0] addr;
        logic [2:0]  n_fill;
    } cmd_hdr_t;

    function automatic logic kind_is_buf(input logic [2:0] k);
        return (k >= 3'd2) && (k <= 3'd5);
    endfunction

    function automatic logic [7:0] kind_opcode(input logic [2:0] k);
        case (k)
            3'd1:    return 8'hD2;
            3'd2:    return 8'hD4;
            3'd3:    return 8'hD6;
            3'd4:    return 8'hD1;
            3'd5:    return 8'hD3;
            default: return 8'h03;
        endcase
    endfunction

    function automatic logic [2:0] kind_fill(input logic [2:0] k);
        if (k == 3'd1)       return 3'd4;
        if (kind_is_buf(k))  return 3'd1;
        return 3'd0;
    endfunction

    function automatic logic [23:0] pack_addr(input logic [2:0] k,
                                              input logic [PAGE_W-1:0] page,
                                              input logic [OFF_W-1:0] off,
                                              input logic bin);
        if (kind_is_buf(k))
            return bin ? {15'b0, off[8:0]} : {14'b0, off};
        return bin ? {2'b0, page, off[8:0]} : {1'b0, page, off};
    endfunction

    function automatic cmd_hdr_t build_hdr(input logic [2:0] k,
                                           input logic [PAGE_W-1:0] page,
                                           input logic [OFF_W-1:0] off,
                                           input logic bin);
        cmd_hdr_t h;
        h.opcode = kind_opcode(k);
        h.addr   = pack_addr(k, page, off, bin);
        h.n_fill = kind_fill(k);
        return h;
    endfunction

endpackage

// File: rtl/sfr_tick.sv
module sfr_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/sfr_header.sv
module sfr_header
    import sfr_pkg::*;
(
    input  logic [2:0]          kind,
    input  logic [PAGE_W-1:0]   page,
    input  logic [OFF_W-1:0]    off,
    input  logic                bin_mode,
    output logic [HDR_BITS-1:0] bits,
    output logic [3:0]          nbytes
);
    cmd_hdr_t h;

    always_comb begin
        h      = build_hdr(kind, page, off, bin_mode);
        bits   = {h.opcode, h.addr, {(HDR_BITS-32){1'b0}}};
        nbytes = 4'd4 + {1'b0, h.n_fill};
    end
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift #(
    parameter int TXW = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [TXW-1:0] load_val,
    input  logic           shift_tx,
    input  logic           shift_rx,
    input  logic           miso,
    output logic           mosi,
    output logic [7:0]     rx_next
);
    logic [TXW-1:0] tx;
    logic [7:0]     rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx <= '0;
            rx <= '0;
        end else begin
            if (load)
                tx <= load_val;
            else if (shift_tx)
                tx <= {tx[TXW-2:0], 1'b0};
            if (load)
                rx <= '0;
            else if (shift_rx)
                rx <= rx_next;
        end
    end

    assign mosi    = tx[TXW-1];
    assign rx_next = {rx[6:0], miso};
endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
    import sfr_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int CNT_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              req_bin,
    input  logic [CNT_W-1:0]  req_count,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int GAP_TICKS = 4;

    seq_state_e          state;
    logic                sck_q, cs_n_q, in_data, rd_valid_q, done_q;
    logic [7:0]          rd_data_q;
    logic [3:0]          hdr_left;
    logic [CNT_W-1:0]    data_left;
    logic [2:0]          bitn;
    logic [2:0]          gap_cnt;
    logic                tick, accept, rise, fall;
    logic [HDR_BITS-1:0] hdr_bits;
    logic [3:0]          hdr_n;
    logic [7:0]          rx_next;

    assign req_ready = (state == S_IDLE) && !rd_valid_q;
    assign accept    = req_valid && req_ready;
    assign rise      = tick && (state == S_XFER) && !sck_q && !(in_data && rd_valid_q);
    assign fall      = tick && (state == S_XFER) && sck_q;

    sfr_tick #(.HALF(HALF_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .en  (state != S_IDLE),
        .tick(tick)
    );

    sfr_header u_hdr (
        .kind    (req_kind),
        .page    (req_page),
        .off     (req_offset),
        .bin_mode(req_bin),
        .bits    (hdr_bits),
        .nbytes  (hdr_n)
    );

    sfr_shift #(.TXW(HDR_BITS)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .load_val(hdr_bits),
        .shift_tx(fall),
        .shift_rx(rise),
        .miso    (spi_miso),
        .mosi    (spi_mosi),
        .rx_next (rx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            sck_q      <= 1'b0;
            cs_n_q     <= 1'b1;
            in_data    <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            done_q     <= 1'b0;
            hdr_left   <= '0;
            data_left  <= '0;
            bitn       <= '0;
            gap_cnt    <= '0;
        end else begin
            done_q <= 1'b0;
            if (rd_valid_q && rd_ready)
                rd_valid_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        state     <= S_XFER;
                        cs_n_q    <= 1'b0;
                        in_data   <= 1'b0;
                        hdr_left  <= hdr_n;
                        data_left <= req_count;
                        bitn      <= '0;
                    end
                end
                S_XFER: begin
                    if (rise) begin
                        sck_q <= 1'b1;
                        bitn  <= bitn + 3'd1;
                        if (bitn == 3'd7) begin
                            if (in_data) begin
                                rd_data_q  <= rx_next;
                                rd_valid_q <= 1'b1;
                                data_left  <= data_left - CNT_W'(1);
                            end else begin
                                hdr_left <= hdr_left - 4'd1;
                            end
                        end
                    end else if (fall) begin
                        sck_q <= 1'b0;
                        if (bitn == 3'd0) begin
                            if (!in_data && hdr_left == 4'd0) begin
                                in_data <= 1'b1;
                                if (data_left == '0)
                                    state <= S_TAIL;
                            end else if (in_data && data_left == '0) begin
                                state <= S_TAIL;
                            end
                        end
                    end
                end
                S_TAIL: begin
                    if (tick) begin
                        cs_n_q  <= 1'b1;
                        done_q  <= 1'b1;
                        gap_cnt <= '0;
                        state   <= S_GAP;
                    end
                end
                default: begin
                    if (tick) begin
                        gap_cnt <= gap_cnt + 3'd1;
                        if (gap_cnt == 3'(GAP_TICKS - 1))
                            state <= S_IDLE;
                    end
                end
            endcase
        end
    end

    assign spi_sck  = sck_q;
    assign spi_cs_n = cs_n_q;
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign done     = done_q;
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
    parameter int HALF_DIV = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       done,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       spi_mosi
);
    localparam logic [15:0] HIGH_MAX = 16'hFFFF;
    logic [15:0] cs_high_run;

    always_ff @(posedge clk) begin
        if (rst)
            cs_high_run <= HIGH_MAX;
        else if (spi_cs_n)
            cs_high_run <= (cs_high_run == HIGH_MAX) ? HIGH_MAX : cs_high_run + 16'd1;
        else
            cs_high_run <= '0;
    end

    p_sck_idle_r1: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    p_mosi_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && !$fell(spi_cs_n) && !$fell(spi_sck)) |-> $stable(spi_mosi));

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_stall_sck_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !$rose(spi_sck));

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (spi_cs_n && !rd_valid));

    p_done_cs_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> spi_cs_n);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (cs_high_run >= 16'(4 * HALF_DIV)));
endmodule

bind flash_read_seq sfr_checker #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .done     (done),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/sim_flash_read_seq.sv
module sim_flash_read_seq;
    localparam int HALF = 2;
    localparam int CNTW = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready, req_bin = 1'b0;
    logic [2:0] req_kind = '0;
    logic [12:0] req_page = '0;
    logic [9:0] req_offset = '0;
    logic [CNTW-1:0] req_count = '0;
    logic rd_valid, rd_ready = 1'b1, done;
    logic [7:0] rd_data;
    logic spi_cs_n, spi_sck, spi_mosi, spi_miso = 1'b1;

    flash_read_seq #(.HALF_DIV(HALF), .CNT_W(CNTW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_page(req_page), .req_offset(req_offset),
        .req_bin(req_bin), .req_count(req_count), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int n_tests = 0, n_fail = 0, n_done = 0, n_issued = 0;
    bit slow_ready = 0;
    longint cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] op, input int j);
        return 8'hC3 ^ op ^ 8'(j * 29);
    endfunction

    function automatic int hlen(input logic [7:0] op);
        if (op == 8'hD2) return 8;
        if (op == 8'hD1 || op == 8'hD3 || op == 8'hD4 || op == 8'hD6) return 5;
        return 4;
    endfunction

    // scoreboard queues
    logic [63:0] eh_q[$];
    int          ehl_q[$];
    int          ecnt_q[$];
    string       etag_q[$];
    logic [7:0]  ed_q[$];

    task automatic issue(input logic [2:0] k, input logic [12:0] pg, input logic [9:0] off,
                         input logic bin, input int cnt, input string atag);
        logic [7:0] op;
        logic [23:0] ad;
        int nf;
        bit isbuf;
        isbuf = (k >= 3'd2 && k <= 3'd5);
        case (k)
            3'd1: begin op = 8'hD2; nf = 4; end
            3'd2: begin op = 8'hD4; nf = 1; end
            3'd3: begin op = 8'hD6; nf = 1; end
            3'd4: begin op = 8'hD1; nf = 1; end
            3'd5: begin op = 8'hD3; nf = 1; end
            default: begin op = 8'h03; nf = 0; end
        endcase
        if (isbuf) ad = bin ? {15'b0, off[8:0]} : {14'b0, off};
        else       ad = bin ? {2'b0, pg, off[8:0]} : {1'b0, pg, off};
        eh_q.push_back({op, ad, 32'h0});
        ehl_q.push_back(4 + nf);
        ecnt_q.push_back(cnt);
        etag_q.push_back(atag);
        for (int j = 0; j < cnt; j++) ed_q.push_back(pat(op, j));
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_kind = k; req_page = pg; req_offset = off; req_bin = bin;
        req_count = CNTW'(cnt); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_issued++;
        chk(!req_ready, "R10 busy after accept", req_ready, 0);
    endtask

    task automatic drain();
        @(negedge clk);
        while (!(req_ready && eh_q.size() == 0 && ed_q.size() == 0)) @(negedge clk);
    endtask

    always @(posedge clk) cyc++;

    always @(posedge clk) begin
        #1 rd_ready = slow_ready ? (cyc % 5 == 0) : 1'b1;
    end

    // flash model
    int nrise = 0;
    logic [7:0] sh;
    logic [7:0] cap[$];
    bit armed = 0, seen_rise = 0;
    longint t_csf = 0, t_r1 = 0, t_csr = 0;

    always @(negedge spi_cs_n) begin
        if (seen_rise)
            chk(cyc - t_csr >= 4 * HALF, "R10 chip select gap", cyc - t_csr, 4 * HALF);
        nrise = 0;
        cap.delete();
        spi_miso = 1'b1;
        armed = 1;
        t_csf = cyc;
    end

    always @(posedge spi_sck) begin
        if (armed && !spi_cs_n) begin
            sh = {sh[6:0], spi_mosi};
            nrise++;
            if (nrise == 1) begin
                t_r1 = cyc;
                chk(cyc - t_csf == HALF, "R11 first rise delay", cyc - t_csf, HALF);
            end
            if (nrise == 2)
                chk(cyc - t_r1 == 2 * HALF, "R11 sck period", cyc - t_r1, 2 * HALF);
            if (nrise % 8 == 0) cap.push_back(sh);
        end
    end

    always @(negedge spi_sck) begin : drive_miso
        int hl, d;
        logic [7:0] b;
        if (armed && !spi_cs_n) begin
            hl = (cap.size() > 0) ? hlen(cap[0]) : 8;
            if (nrise >= 8 * hl) begin
                d = nrise - 8 * hl;
                b = pat(cap[0], d / 8);
                spi_miso = b[7 - (d % 8)];
            end else begin
                spi_miso = 1'b1;
            end
        end
    end

    always @(posedge spi_cs_n) begin : end_txn
        logic [63:0] eh;
        int ehl, ecnt;
        string tg;
        if (armed) begin
            armed = 0;
            seen_rise = 1;
            t_csr = cyc;
            if (eh_q.size() == 0) begin
                chk(0, "R1 unexpected transaction", cap.size(), 0);
            end else begin
                eh = eh_q.pop_front(); ehl = ehl_q.pop_front();
                ecnt = ecnt_q.pop_front(); tg = etag_q.pop_front();
                chk(nrise % 8 == 0, "R1 whole bytes", nrise, (nrise / 8) * 8);
                chk(cap.size() == ehl + ecnt, (ecnt == 0) ? "R1 R9 byte count" : "R1 byte count",
                    cap.size(), ehl + ecnt);
                for (int i = 0; i < ehl && i < cap.size(); i++) begin
                    if (i == 0)
                        chk(cap[i] == eh[63 -: 8], "R2 opcode", cap[i], eh[63 -: 8]);
                    else if (i < 4)
                        chk(cap[i] == eh[63 - 8 * i -: 8], tg, cap[i], eh[63 - 8 * i -: 8]);
                    else
                        chk(cap[i] == 8'h00, "R3 filler byte", cap[i], 0);
                end
            end
        end
    end

    // stream monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid && rd_ready) begin
                if (ed_q.size() == 0)
                    chk(0, "R8 R9 unexpected data byte", rd_data, 0);
                else
                    chk(rd_data == ed_q[0], "R3 R7 R8 data byte", rd_data, ed_q[0]);
                if (ed_q.size() != 0) void'(ed_q.pop_front());
            end
            if (done) begin
                n_done++;
                chk(spi_cs_n, "R10 done with chip select high", spi_cs_n, 1);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 reset chip select", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 reset sck", spi_sck, 0);
        chk(rd_valid == 1'b0, "R8 reset rd_valid", rd_valid, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);

        issue(3'd0, 13'h1ABC, 10'h2F5, 1'b0, 5, "R4 address 528 main");
        issue(3'd0, 13'h0123, 10'h3FF, 1'b1, 3, "R5 address 512 main");
        issue(3'd1, 13'h1555, 10'h0AA, 1'b0, 4, "R4 address page read");
        issue(3'd1, 13'h0F0F, 10'h201, 1'b1, 2, "R5 address page read 512");
        issue(3'd2, 13'h1FFF, 10'h3A5, 1'b0, 2, "R6 buffer address 528");
        issue(3'd3, 13'h1FFF, 10'h3A5, 1'b1, 2, "R6 buffer address 512");
        issue(3'd4, 13'h0001, 10'h155, 1'b0, 1, "R6 buffer address slow");
        issue(3'd5, 13'h0002, 10'h2AA, 1'b1, 1, "R6 buffer address slow 512");
        issue(3'd6, 13'h0A0A, 10'h0C3, 1'b0, 1, "R2 R4 reserved kind address");
        issue(3'd1, 13'h1234, 10'h111, 1'b0, 0, "R9 R4 zero count address");
        issue(3'd2, 13'h0000, 10'h000, 1'b1, 0, "R9 R6 zero count buffer");
        drain();

        slow_ready = 1;
        issue(3'd0, 13'h0777, 10'h1E0, 1'b0, 6, "R8 R4 stalled read address");
        drain();
        slow_ready = 0;
        repeat (20) @(negedge clk);

        chk(n_done == n_issued, "R10 done count", n_done, n_issued);
        chk(eh_q.size() == 0, "R1 pending transactions", eh_q.size(), 0);
        chk(ed_q.size() == 0, "R8 pending data", ed_q.size(), 0);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 idle lines", {spi_cs_n, spi_sck}, 2'b10);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule